// File: doc/BRIEF.md
# Page Write Load Controller

This block is the host-side write path of a byte-wide nonvolatile memory model. The host drives a strobe interface made of chip-select, write-strobe and read-strobe lines. These lines are active low and already synchronised to the system clock. The host writes bytes into a page buffer, and each accepted byte opens a fresh load window. When the window lapses with no new byte, the block commits the buffered page to a register-based array. It does this through an internally timed program phase, which is modelled as a cycle counter. No new traffic can interrupt that phase.

A page is a run of `2**OFF_W` consecutive bytes. The low `OFF_W` address bits pick the byte within the page and the remaining upper bits pick the page. Only the bytes that were actually loaded are written, because a per-slot valid mask guards the commit. If the loaded bytes do not all share one page number, the whole load is thrown away. During the program phase the read data carries a status byte instead of array contents. That status byte holds an inverted-data poll bit, a bit that toggles on each read and a fixed "programming" flag.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset every array byte reads 8'hFF, `phase` is 0 (idle) and `busy` is low.
- R2: A byte is accepted only while `cs_n`=0, `wr_n`=0 and `rd_n`=1. A strobe with `rd_n` low, or with `cs_n` high, leaves `phase` at 0 and the array unchanged.
- R3: The address is taken in the first cycle in which the write condition holds. The data is taken in the first cycle in which it no longer holds. Later address changes within the strobe are not used, and data values driven before the release are not used.
- R4: On commit, each loaded byte is stored at {page, offset}. Bytes of that page that were not loaded keep their old values. Committing requires a program phase (`phase` 2); `phase` never passes straight from 0 to 2.
- R5: Each accepted byte moves `phase` to 1 (loading) and restarts the window. `phase` stays 1 until `LOAD_WIN_CYC` cycles pass with no accepted byte.
- R6: If any loaded byte has a page number different from the first byte's, the load is discarded when the window lapses. `phase` then returns to 0 without `busy` rising, and nothing in the array changes.
- R7: The program phase (`busy`=1, `phase`=2) lasts exactly `WRITE_CYC` cycles and then returns to 0.
- R8: Writes during the program phase are ignored. They do not reopen a load and they do not reach the array.
- R9: While `busy` is high, `rdata` is a status byte. Bit 7 is the inverse of bit 7 of the last byte loaded. Bit 6 reads 0 on the first read access of the phase and flips after each read access ends. Bit 5 is 1 and bits 4:0 are 0.
- R10: A single loaded byte is committed as a one-byte page.
- R11: While not busy, `rdata` is the array byte at `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, synchronised |
| wr_n | input | 1 | Write strobe, active low, synchronised |
| rd_n | input | 1 | Read/output strobe, active low, synchronised |
| addr | input | ADDR_W | Byte address, {page, offset} |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Array byte, or status byte while busy |
| busy | output | 1 | Program phase in progress |
| phase | output | 2 | 0 idle, 1 loading, 2 programming |

## Verification
The assertions take as given that the strobe lines are already clean and synchronous. They also assume that each enable level is held for at least one clock, and that write data is still valid in the cycle where the write condition first drops. The bench keeps to this by driving every input on the falling clock edge. It holds each strobe level for two or more cycles and keeps `wdata` steady after a strobe until the next one begins. It never asserts a read and a write in the same access.

// File: rtl/pwc_pkg.sv
// Package: shared phase encoding for the page write load controller.
// Assumes: the encoding is visible on the top-level phase port.
package pwc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;
endpackage

// File: rtl/pwc_strobe.sv
// Strobe decoder: turns synchronised enable levels into an accepted-byte pulse.
// The address is latched when the write condition starts, and the data is taken
// when it ends. A write is dropped if the program phase is active at its start or end.
// Assumes: inputs are synchronous, each level is held for at least one cycle.
module pwc_strobe #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hold_off,
    output logic              byte_vld,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [DATA_W-1:0] byte_data,
    output logic              rd_done
);
    logic wr_act, rd_act;
    logic wr_q, rd_q, skip_q;
    logic [ADDR_W-1:0] addr_lat;

    // Decode the write and read conditions from the enable levels.
    always_comb begin
        wr_act = !cs_n && !wr_n && rd_n;
        rd_act = !cs_n && !rd_n && wr_n;
    end

    // Track previous conditions; latch the address at the start of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            skip_q   <= 1'b0;
            addr_lat <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (wr_act && !wr_q) begin
                addr_lat <= addr;
                skip_q   <= hold_off;
            end
        end
    end

    // Emit the byte at the end of the write, taking data from that cycle.
    always_comb begin
        byte_vld  = wr_q && !wr_act && !hold_off && !skip_q;
        byte_addr = addr_lat;
        byte_data = wdata;
        rd_done   = rd_q && !rd_act;
    end
endmodule

// File: rtl/pwc_page_buf.sv
// Page buffer: one data slot per byte of a page, a valid mask, the page number of
// the first loaded byte, a sticky page-mismatch flag and the last loaded byte.
// Assumes: clear and load never fall in the same cycle (the sequencer ensures it).
module pwc_page_buf #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 6
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load,
    input  logic                                  clear,
    input  logic [ADDR_W-1:0]                     ld_addr,
    input  logic [DATA_W-1:0]                     ld_data,
    output logic [(1<<OFF_W)-1:0][DATA_W-1:0]     slot_data,
    output logic [(1<<OFF_W)-1:0]                 slot_mask,
    output logic [ADDR_W-OFF_W-1:0]               page_num,
    output logic                                  mismatch,
    output logic [DATA_W-1:0]                     last_data
);
    localparam int PAGE_SZ = 1 << OFF_W;
    localparam int PG_W    = ADDR_W - OFF_W;

    logic [OFF_W-1:0] ld_off;
    logic [PG_W-1:0]  ld_page;

    // Split the load address into page and offset.
    always_comb begin
        ld_off  = ld_addr[OFF_W-1:0];
        ld_page = ld_addr[ADDR_W-1:OFF_W];
    end

    for (genvar g = 0; g < PAGE_SZ; g++) begin : g_slot
        // Store one byte into its slot when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_data[g] <= '0;
            else if (load && (ld_off == OFF_W'(g)))
                slot_data[g] <= ld_data;
        end
    end

    // Maintain mask, page number, mismatch flag and last loaded byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            slot_mask <= '0;
            page_num  <= '0;
            mismatch  <= 1'b0;
            if (!rst_n) last_data <= '0;
        end else if (load) begin
            slot_mask[ld_off] <= 1'b1;
            last_data         <= ld_data;
            if (slot_mask == '0)
                page_num <= ld_page;
            else if (ld_page != page_num)
                mismatch <= 1'b1;
        end
    end
endmodule

// File: rtl/pwc_seq.sv
// Write-cycle sequencer: idle, loading (window timer), programming (cycle timer).
// A lapsed window either starts programming or discards a mixed-page load.
// Assumes: LOAD_WIN_CYC and WRITE_CYC are both at least 2.
module pwc_seq
    import pwc_pkg::*;
#(
    parameter int LOAD_WIN_CYC = 15000,
    parameter int WRITE_CYC    = 500000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   byte_vld,
    input  logic   mismatch,
    output phase_e phase,
    output logic   commit,
    output logic   clear,
    output logic   prog_start
);
    localparam int MAX_C = (LOAD_WIN_CYC > WRITE_CYC) ? LOAD_WIN_CYC : WRITE_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);

    logic [CNT_W-1:0] cnt;
    logic win_done, prog_done, discard;

    // Decode timer end points and the resulting one-cycle actions.
    always_comb begin
        win_done   = (phase == PH_LOAD) && !byte_vld && (cnt == CNT_W'(LOAD_WIN_CYC - 1));
        prog_done  = (phase == PH_PROG) && (cnt == CNT_W'(WRITE_CYC - 1));
        discard    = win_done && mismatch;
        prog_start = win_done && !mismatch;
        commit     = prog_done;
        clear      = prog_done || discard;
    end

    // Advance the phase and its shared timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (byte_vld) begin
                    phase <= PH_LOAD;
                    cnt   <= '0;
                end
                PH_LOAD: begin
                    if (byte_vld)        cnt <= '0;
                    else if (prog_start) begin phase <= PH_PROG; cnt <= '0; end
                    else if (discard)    begin phase <= PH_IDLE; cnt <= '0; end
                    else                 cnt <= cnt + 1'b1;
                end
                PH_PROG: begin
                    if (prog_done) begin phase <= PH_IDLE; cnt <= '0; end
                    else           cnt <= cnt + 1'b1;
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pwc_array.sv
// Register-based byte array, reset to all ones, with a page-wide masked commit port
// and an asynchronous read port.
// Assumes: DEPTH = 2**ADDR_W stays small enough for flop storage in the model.
module pwc_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [ADDR_W-OFF_W-1:0]           page_num,
    input  logic [(1<<OFF_W)-1:0]             slot_mask,
    input  logic [(1<<OFF_W)-1:0][DATA_W-1:0] slot_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int PAGE_SZ = 1 << OFF_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Initialise to erased state; on commit write only the masked slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '1;
        end else if (commit) begin
            for (int i = 0; i < PAGE_SZ; i++)
                if (slot_mask[i]) mem[{page_num, OFF_W'(i)}] <= slot_data[i];
        end
    end

    // Present the addressed byte.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/page_write_ctrl.sv
// Top of the page write load controller. It connects the strobe decoder, page buffer,
// sequencer and array, and forms the status byte returned during programming.
// Assumes: strobe inputs are synchronised; rdata is not gated by the read strobe.
module page_write_ctrl
    import pwc_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int OFF_W        = 6,
    parameter int LOAD_WIN_CYC = 15000,
    parameter int WRITE_CYC    = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic [1:0]        phase
);
    localparam int PAGE_SZ = 1 << OFF_W;
    localparam int PG_W    = ADDR_W - OFF_W;

    logic                              byte_vld, rd_done;
    logic [ADDR_W-1:0]                 byte_addr;
    logic [DATA_W-1:0]                 byte_data, last_data, arr_rd;
    logic [PAGE_SZ-1:0][DATA_W-1:0]    slot_data;
    logic [PAGE_SZ-1:0]                slot_mask;
    logic [PG_W-1:0]                   page_num;
    logic                              mismatch, commit, clear, prog_start;
    logic                              tog_q;
    phase_e                            ph;

    pwc_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) strobe_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .wdata(wdata), .hold_off(busy),
        .byte_vld(byte_vld), .byte_addr(byte_addr), .byte_data(byte_data),
        .rd_done(rd_done)
    );

    pwc_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) buf_i (
        .clk(clk), .rst_n(rst_n), .load(byte_vld), .clear(clear),
        .ld_addr(byte_addr), .ld_data(byte_data),
        .slot_data(slot_data), .slot_mask(slot_mask), .page_num(page_num),
        .mismatch(mismatch), .last_data(last_data)
    );

    pwc_seq #(.LOAD_WIN_CYC(LOAD_WIN_CYC), .WRITE_CYC(WRITE_CYC)) seq_i (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .mismatch(mismatch),
        .phase(ph), .commit(commit), .clear(clear), .prog_start(prog_start)
    );

    pwc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) array_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .page_num(page_num),
        .slot_mask(slot_mask), .slot_data(slot_data),
        .rd_addr(addr), .rd_data(arr_rd)
    );

    // Toggle status bit: zero at the start of programming, flips per finished read.
    always_ff @(posedge clk) begin
        if (!rst_n || prog_start) tog_q <= 1'b0;
        else if (busy && rd_done) tog_q <= ~tog_q;
    end

    // Drive phase, busy and the read mux (status byte while programming).
    always_comb begin
        phase = ph;
        busy  = (ph == PH_PROG);
        if (busy)
            rdata = {~last_data[DATA_W-1], tog_q, 1'b1, {(DATA_W-3){1'b0}}};
        else
            rdata = arr_rd;
    end
endmodule

// File: rtl/pwc_checker.sv
// Checker for page_write_ctrl: phase legality, window and program lengths,
// and the status byte format. It observes only the top-level ports.
// Assumes: attached through the bind below with the top's parameters.
module pwc_checker #(
    parameter int DATA_W       = 8,
    parameter int LOAD_WIN_CYC = 15000,
    parameter int WRITE_CYC    = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] rdata,
    input logic              busy,
    input logic [1:0]        phase
);
    logic     wr_now, wr_prev;
    int unsigned prog_len, gap;

    always_comb wr_now = !cs_n && !wr_n && rd_n;

    // Count busy cycles and cycles since the last accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev  <= 1'b0;
            prog_len <= 0;
            gap      <= 0;
        end else begin
            wr_prev  <= wr_now;
            prog_len <= busy ? prog_len + 1 : 0;
            if (wr_prev && !wr_now && !busy) gap <= 0;
            else if (gap < LOAD_WIN_CYC + 4) gap <= gap + 1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (phase == 2'd0 && !busy));

    assert_no_skip_to_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'd0 |=> phase != 2'd2);

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'd1 |-> gap < LOAD_WIN_CYC);

    assert_prog_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> prog_len == WRITE_CYC);

    assert_busy_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> phase != 2'd1);

    assert_status_format_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rdata[DATA_W-3] && rdata[DATA_W-4:0] == '0));
endmodule

bind page_write_ctrl pwc_checker #(
    .DATA_W(DATA_W), .LOAD_WIN_CYC(LOAD_WIN_CYC), .WRITE_CYC(WRITE_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .rdata(rdata), .busy(busy), .phase(phase)
);

// File: tb/page_write_ctrl_tb_top.sv
// Bench for page_write_ctrl in a small configuration: 4 pages of 64 bytes,
// short load window and program time.
module page_write_ctrl_tb_top;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int LW = 20;
    localparam int WC = 60;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic busy;
    logic [1:0] phase;
    int checks = 0, fails = 0;
    logic [DW-1:0] rv;

    always #5 clk = ~clk;

    page_write_ctrl #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(6),
                      .LOAD_WIN_CYC(LW), .WRITE_CYC(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .phase(phase));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe_lvl);
        addr = a; wdata = d; rd_n = oe_lvl; cs_n = 1'b0; wr_n = 1'b0;
        cyc(3);
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        cyc(2);
    endtask

    task automatic rd_byte(input logic [AW-1:0] a, output logic [DW-1:0] d);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        cyc(1);
        d = rdata;
        cs_n = 1'b1; rd_n = 1'b1;
        cyc(1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && phase != 2'd0; i++) cyc(1);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 7 + 3);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cyc(3); rst_n = 1'b1; cyc(1);
        // R1: erased contents and idle state
        check("R1 phase", phase, 0);
        check("R1 busy", busy, 0);
        for (int a = 0; a < 256; a += 37) begin rd_byte(AW'(a), rv); check("R1 erased", rv, 8'hFF); end

        // R10 single byte, R9 status, R8 ignored write, R7 length
        wr_byte(8'h05, 8'h3C, 1'b1);
        check("R5 loading after byte", phase, 1);
        cyc(LW + 4);
        check("R7 busy entered", busy, 1);
        rd_byte(8'h05, rv); check("R9 status first read", rv, 8'hA0);
        rd_byte(8'h22, rv); check("R9 status second read", rv, 8'hE0);
        wr_byte(8'h06, 8'h11, 1'b1);
        check("R8 still programming", phase, 2);
        wait_idle();
        check("R7 back to idle", phase, 0);
        rd_byte(8'h05, rv); check("R10 single byte stored", rv, 8'h3C);
        rd_byte(8'h06, rv); check("R8 busy write dropped", rv, 8'hFF);
        rd_byte(8'h04, rv); check("R4 unloaded neighbour", rv, 8'hFF);

        // R5 full-page sweep, R4 commit, R11 reads
        for (int i = 0; i < 64; i++) begin
            wr_byte(AW'(64 + i), pat(i), 1'b1);
            if (i % 16 == 15) check("R5 window restarted", phase, 1);
        end
        wait_idle();
        for (int i = 0; i < 64; i++) begin
            rd_byte(AW'(64 + i), rv); check("R4 R11 page byte", rv, pat(i));
        end

        // R3 address from start, data from end
        addr = 8'h90; wdata = 8'h00; cs_n = 1'b0; wr_n = 1'b0;
        cyc(2); addr = 8'h91; wdata = 8'h77;
        cyc(2); wdata = 8'h5A;
        cyc(1); cs_n = 1'b1; wr_n = 1'b1;
        cyc(2);
        wait_idle();
        rd_byte(8'h90, rv); check("R3 data at release", rv, 8'h5A);
        rd_byte(8'h91, rv); check("R3 late address unused", rv, 8'hFF);

        // R2 write with read strobe low, and with chip select high
        wr_byte(8'hA0, 8'h12, 1'b0);
        check("R2 oe low no load", phase, 0);
        addr = 8'hA1; wdata = 8'h34; wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(2);
        check("R2 cs high no load", phase, 0);
        rd_byte(8'hA0, rv); check("R2 array A0", rv, 8'hFF);
        rd_byte(8'hA1, rv); check("R2 array A1", rv, 8'hFF);

        // R6 mixed pages discarded
        wr_byte(8'hC0, 8'h12, 1'b1);
        wr_byte(8'h10, 8'h34, 1'b1);
        begin
            int seen = 0;
            for (int i = 0; i < LW + 20; i++) begin cyc(1); if (busy) seen = 1; end
            check("R6 no program phase", seen, 0);
        end
        check("R6 idle after discard", phase, 0);
        rd_byte(8'hC0, rv); check("R6 C0 untouched", rv, 8'hFF);
        rd_byte(8'h10, rv); check("R6 10 untouched", rv, 8'hFF);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule